// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block holds the byte-level state of an SMBus host controller while it runs block transfers. Software reaches it through one byte-wide data window and a set of status controls. A neighbouring bus sequencer moves the bits on the wire. The block keeps a 32-byte buffer, a 6-bit index, the byte count, a single holding byte, the operation-done flag, and the busy, byte-done, interrupt and device-error status bits. Through request pulses it tells the sequencer when to transmit a finished block write, when to fill the buffer for a block read, and when to fetch one byte of an I2C-style block read.

The block has two access modes, picked by the `buffered` level at the moment of a start. In buffered mode the data window maps onto the buffer, and each access moves an auto-incrementing index. In byte mode the window is a single holding byte. Software steps the transfer by clearing byte-done once per byte, and on a read the last-byte control ends the transfer. A start that arrives while an earlier operation is still unfinished first aborts that operation. If an I2C block read is open, the abort also ends it with a stop request.

Top module: `smb_blkbuf`

## Requirements
- R1: In buffered mode, a `blk_we` stores `blk_wdata` into the buffer at the current index, and the index then moves up by one. The stored byte can be read back on `tx_data` at that address.
- R2: In buffered mode, `blk_rdata` shows the buffer byte at the current index, and a `blk_re` advances the index. When the advanced index equals the count during an unfinished operation, `op_done` sets, the index returns to 0 and `busy` clears.
- R3: The index wraps, so an access made at index 32 uses position 0. The 33rd buffered write after index 0 overwrites buffer position 0.
- R4: A buffered write start (`start_read`=0, `start_i2c`=0, `buffered`=1) checks the index against the count. If they match, the next cycle shows a one-cycle `xmit_req` with `intr`=1, `busy`=0 and `op_done`=1. If they do not match, `dev_err` sets, the index resets and no request is issued.
- R5: A start is not executed while `dev_err` is 1. `busy` stays 0 and no request pulse appears.
- R6: A byte-mode write start copies the holding byte into buffer position 0 and sets `busy` and `byte_done`. Each later clear of byte-done advances the index and stores the holding byte at the new index. When the new index equals the count, the block pulses `xmit_req` instead, sets `intr` and clears `busy`.
- R7: A `clr_bdone` pulse advances a byte-mode transfer only when `byte_done` is 1 and an operation is unfinished. Otherwise it starts no request and does not touch the holding byte.
- R8: In a byte-mode buffered-fill read, the first byte appears on `blk_rdata` when `fill_done` arrives, and each clear of byte-done presents the next byte. A clear made while `last_byte`=1 presents the final byte, sets `intr`, clears `busy` and sets `op_done`.
- R9: An I2C block read (`start_i2c`=1) pulses `rx_req` at the start and after each clear of byte-done. A byte delivered on `rx_valid` sets `byte_done` and appears on `blk_rdata`. A clear made with `last_byte`=1 pulses `rx_last_req` instead, and the byte that follows finishes the operation with `intr`=1 and `busy`=0. Only one request pulse is active in any cycle.
- R10: A start while an operation is unfinished aborts that operation and resets the index. If an I2C block read was open, `stop_req` pulses in the cycle that follows.
- R11: A buffered read start pulses `fill_req`. At `fill_done` the count is loaded from `fill_data` and `intr` sets, while `busy` stays 1 until software has read the counted bytes.
- R12: After reset, `busy`, `byte_done`, `intr` and `dev_err` are 0 and `op_done` is 1.
- R13: In byte mode, a `blk_we` loads only the holding byte, which then shows on `blk_rdata`. The buffer contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buffered | input | 1 | 1 selects buffered mode, 0 selects byte mode |
| blk_we | input | 1 | Write strobe for the data window |
| blk_wdata | input | 8 | Write data for the data window |
| blk_re | input | 1 | Read strobe for the data window (causes the index side effect) |
| blk_rdata | output | 8 | Data window read value |
| cnt_we | input | 1 | Load strobe for the byte count |
| cnt_wdata | input | 8 | New byte count |
| cnt_q | output | 8 | Current byte count |
| start | input | 1 | Start pulse for a transfer |
| start_read | input | 1 | Transfer direction at start, 1 for read |
| start_i2c | input | 1 | 1 selects an I2C block read at start |
| last_byte | input | 1 | Last-byte control level for byte-mode reads |
| clr_bdone | input | 1 | Software clear of byte-done |
| clr_intr | input | 1 | Software clear of interrupt |
| clr_err | input | 1 | Software clear of device error |
| busy | output | 1 | Host busy |
| byte_done | output | 1 | Byte-done status |
| intr | output | 1 | Completion interrupt status |
| dev_err | output | 1 | Device error status |
| op_done | output | 1 | No operation in progress |
| xmit_req | output | 1 | Pulse asking the sequencer to transmit the buffered block |
| fill_req | output | 1 | Pulse asking the sequencer to fill the buffer for a read |
| rx_req | output | 1 | Pulse asking for one I2C read byte |
| rx_last_req | output | 1 | Pulse asking for the final I2C read byte with NACK and stop |
| stop_req | output | 1 | Pulse asking for a stop that ends an aborted I2C read |
| fill_we | input | 1 | Sequencer writes the next fill byte |
| fill_data | input | 8 | Fill byte, or the byte count when fill_done is high |
| fill_done | input | 1 | Sequencer has finished the fill |
| rx_valid | input | 1 | I2C read byte is valid |
| rx_data | input | 8 | I2C read byte |
| tx_addr | input | 5 | Buffer address the sequencer reads |
| tx_data | output | 8 | Buffer byte at tx_addr |

## Verification
The properties assume that at most one of start, a byte-done clear, a fill completion or a received byte arrives in any cycle. They also assume the sequencer answers only the request that is outstanding, and that `last_byte` holds steady around the clear it qualifies. Under those assumptions the request pulses are mutually exclusive. The bench keeps to this by driving every control as a single-cycle pulse on the falling edge, separated from the next one. It answers each request only after it has seen that request at the port.

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int IW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buffered,
  input  logic          blk_we,
  input  logic [7:0]    blk_wdata,
  input  logic          blk_re,
  output logic [7:0]    blk_rdata,
  input  logic          cnt_we,
  input  logic [7:0]    cnt_wdata,
  output logic [7:0]    cnt_q,
  input  logic          start,
  input  logic          start_read,
  input  logic          start_i2c,
  input  logic          last_byte,
  input  logic          clr_bdone,
  input  logic          clr_intr,
  input  logic          clr_err,
  output logic          busy,
  output logic          byte_done,
  output logic          intr,
  output logic          dev_err,
  output logic          op_done,
  output logic          xmit_req,
  output logic          fill_req,
  output logic          rx_req,
  output logic          rx_last_req,
  output logic          stop_req,
  input  logic          fill_we,
  input  logic [7:0]    fill_data,
  input  logic          fill_done,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic [AW-1:0] tx_addr,
  output logic [7:0]    tx_data
);

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] idx;
  logic [7:0]    hold;
  logic [AW-1:0] fptr;
  logic          m_read, m_buf, i2c_open, wait_rx, wait_last, wait_fill;

  logic [IW-1:0] idx_w, idx_nx, adv;
  logic          adv_bd, rd_mode, win_buf;
  logic          mem_we;
  logic [AW-1:0] mem_wa;
  logic [7:0]    mem_wd;

  assign idx_w   = (idx >= IW'(DEPTH)) ? '0 : idx;
  assign idx_nx  = idx_w + 1'b1;
  assign adv     = (idx_nx >= IW'(DEPTH)) ? '0 : idx_nx;
  assign win_buf = buffered && !i2c_open;
  assign rd_mode = m_read || i2c_open;
  assign adv_bd  = byte_done && clr_bdone && !op_done && (i2c_open || !m_buf);

  assign blk_rdata = win_buf ? mem[idx_w[AW-1:0]] : hold;
  assign tx_data   = mem[tx_addr];
  assign cnt_q     = cnt_q_r;

  logic [7:0] cnt_q_r;

  always_comb begin
    mem_we = 1'b0;
    mem_wa = '0;
    mem_wd = hold;
    if (fill_we) begin
      mem_we = 1'b1; mem_wa = fptr; mem_wd = fill_data;
    end else if (start && !dev_err && !start_read && !start_i2c && !buffered) begin
      mem_we = 1'b1; mem_wa = '0;
    end else if (adv_bd && !rd_mode && 8'(adv) != cnt_q_r) begin
      mem_we = 1'b1; mem_wa = adv[AW-1:0];
    end else if (blk_we && buffered) begin
      mem_we = 1'b1; mem_wa = idx_w[AW-1:0]; mem_wd = blk_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0; hold <= '0; fptr <= '0; cnt_q_r <= '0;
      m_read <= 1'b0; m_buf <= 1'b0; i2c_open <= 1'b0;
      wait_rx <= 1'b0; wait_last <= 1'b0; wait_fill <= 1'b0;
      busy <= 1'b0; byte_done <= 1'b0; intr <= 1'b0; dev_err <= 1'b0; op_done <= 1'b1;
      xmit_req <= 1'b0; fill_req <= 1'b0; rx_req <= 1'b0; rx_last_req <= 1'b0; stop_req <= 1'b0;
    end else begin
      xmit_req <= 1'b0; fill_req <= 1'b0; rx_req <= 1'b0; rx_last_req <= 1'b0; stop_req <= 1'b0;
      if (clr_intr)  intr <= 1'b0;
      if (clr_err)   dev_err <= 1'b0;
      if (clr_bdone) byte_done <= 1'b0;
      if (cnt_we)    cnt_q_r <= cnt_wdata;
      if (fill_we)   fptr <= fptr + 1'b1;

      if (blk_we) begin
        if (buffered) idx <= idx_nx;
        else          hold <= blk_wdata;
      end

      if (blk_re && win_buf) begin
        idx <= idx_nx;
        if (!op_done && 8'(idx_nx) == cnt_q_r) begin
          op_done <= 1'b1; idx <= '0; busy <= 1'b0;
        end
      end

      if (fill_done && wait_fill) begin
        wait_fill <= 1'b0;
        cnt_q_r   <= fill_data;
        idx       <= '0;
        if (m_buf) intr <= 1'b1;
        else begin
          hold <= mem[0]; byte_done <= 1'b1;
        end
      end

      if (rx_valid) begin
        if (wait_last) begin
          hold <= rx_data; op_done <= 1'b1; intr <= 1'b1; busy <= 1'b0;
          i2c_open <= 1'b0; idx <= '0; wait_last <= 1'b0;
        end else if (wait_rx) begin
          hold <= rx_data; byte_done <= 1'b1; wait_rx <= 1'b0;
        end
      end

      if (adv_bd) begin
        if (!rd_mode) begin
          idx <= adv;
          if (8'(adv) == cnt_q_r) begin
            xmit_req <= 1'b1; op_done <= 1'b1; intr <= 1'b1; busy <= 1'b0;
          end else begin
            byte_done <= 1'b1;
          end
        end else if (last_byte) begin
          if (i2c_open) begin
            rx_last_req <= 1'b1; wait_last <= 1'b1; idx <= adv;
          end else begin
            hold <= mem[adv[AW-1:0]]; op_done <= 1'b1; idx <= '0;
            intr <= 1'b1; busy <= 1'b0;
          end
        end else begin
          idx <= adv;
          if (i2c_open) begin
            rx_req <= 1'b1; wait_rx <= 1'b1;
          end else begin
            hold <= mem[adv[AW-1:0]]; byte_done <= 1'b1;
          end
        end
      end

      if (start) begin
        xmit_req <= 1'b0; rx_req <= 1'b0; rx_last_req <= 1'b0;
        m_read <= start_read; m_buf <= buffered; fptr <= '0;
        wait_rx <= 1'b0; wait_last <= 1'b0; wait_fill <= 1'b0;
        i2c_open <= 1'b0; op_done <= 1'b1;
        if (!op_done) begin
          idx <= '0;
          if (i2c_open) stop_req <= 1'b1;
        end
        if (!dev_err) begin
          if (start_i2c) begin
            i2c_open <= 1'b1; wait_rx <= 1'b1; rx_req <= 1'b1;
            op_done <= 1'b0; busy <= 1'b1; m_read <= 1'b1;
          end else if (start_read) begin
            fill_req <= 1'b1; wait_fill <= 1'b1; op_done <= 1'b0; busy <= 1'b1;
          end else if (buffered) begin
            idx <= '0;
            if (8'(idx) != cnt_q_r) begin
              dev_err <= 1'b1;
            end else begin
              xmit_req <= 1'b1; intr <= 1'b1; busy <= 1'b0;
            end
          end else begin
            idx <= '0; op_done <= 1'b0; busy <= 1'b1; byte_done <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk #(
  parameter int DEPTH = 32,
  parameter int IW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          last_byte,
  input logic          clr_bdone,
  input logic          dev_err,
  input logic          intr,
  input logic          busy,
  input logic          op_done,
  input logic          xmit_req,
  input logic          fill_req,
  input logic          rx_req,
  input logic          rx_last_req,
  input logic          stop_req,
  input logic [IW-1:0] idx
);

  assert_xmit_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_req |-> (intr && !busy && op_done));

  assert_err_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_err) |-> $past(start));

  assert_req_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xmit_req, fill_req, rx_req, rx_last_req}));

  assert_last_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_last_req |-> $past(last_byte && clr_bdone));

  assert_stop_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(start));

  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(DEPTH));

endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .last_byte(last_byte),
  .clr_bdone(clr_bdone), .dev_err(dev_err), .intr(intr), .busy(busy),
  .op_done(op_done), .xmit_req(xmit_req), .fill_req(fill_req),
  .rx_req(rx_req), .rx_last_req(rx_last_req), .stop_req(stop_req), .idx(idx)
);

// File: tb/smb_blkbuf_test.sv
module smb_blkbuf_test;
  logic clk = 0, rst_n = 0;
  logic buffered = 0, blk_we = 0, blk_re = 0, cnt_we = 0, start = 0;
  logic start_read = 0, start_i2c = 0, last_byte = 0;
  logic clr_bdone = 0, clr_intr = 0, clr_err = 0;
  logic fill_we = 0, fill_done = 0, rx_valid = 0;
  logic [7:0] blk_wdata = 0, cnt_wdata = 0, fill_data = 0, rx_data = 0;
  logic [4:0] tx_addr = 0;
  logic [7:0] blk_rdata, cnt_q, tx_data;
  logic busy, byte_done, intr, dev_err, op_done;
  logic xmit_req, fill_req, rx_req, rx_last_req, stop_req;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  smb_blkbuf uut (.*);

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr_win(logic [7:0] d); blk_wdata = d; blk_we = 1; tick(); blk_we = 0; endtask
  task automatic rd_win(); blk_re = 1; tick(); blk_re = 0; endtask
  task automatic set_cnt(logic [7:0] d); cnt_wdata = d; cnt_we = 1; tick(); cnt_we = 0; endtask
  task automatic go(logic rd, logic i2c); start_read = rd; start_i2c = i2c; start = 1; tick();
    start = 0; start_read = 0; start_i2c = 0; endtask
  task automatic clr_bd(); clr_bdone = 1; tick(); clr_bdone = 0; endtask
  task automatic clr_int(); clr_intr = 1; tick(); clr_intr = 0; endtask
  task automatic fill(logic [7:0] d); fill_data = d; fill_we = 1; tick(); fill_we = 0; endtask
  task automatic fill_end(logic [7:0] n); fill_data = n; fill_done = 1; tick(); fill_done = 0; endtask
  task automatic rx(logic [7:0] d); rx_data = d; rx_valid = 1; tick(); rx_valid = 0; endtask
  task automatic peek(logic [4:0] a, output logic [7:0] d); tx_addr = a; #1 d = tx_data; endtask

  task automatic t_reset();
    chk("R12 busy", busy, 0); chk("R12 byte_done", byte_done, 0);
    chk("R12 intr", intr, 0); chk("R12 dev_err", dev_err, 0); chk("R12 op_done", op_done, 1);
  endtask

  task automatic t_buf_write();
    logic [7:0] d;
    buffered = 1; set_cnt(3);
    wr_win(8'h11); wr_win(8'h22); wr_win(8'h33);
    go(0, 0);
    chk("R4 xmit_req", xmit_req, 1); chk("R4 intr", intr, 1); chk("R4 busy", busy, 0);
    for (int k = 0; k < 3; k++) begin
      peek(k[4:0], d); chk("R1 stored byte", d, 8'h11 * (k + 1));
    end
    clr_int();
  endtask

  task automatic t_buf_mismatch();
    wr_win(8'h01); wr_win(8'h02);
    go(0, 0);
    chk("R4 dev_err on mismatch", dev_err, 1); chk("R4 no xmit", xmit_req, 0);
    chk("R4 no intr", intr, 0);
    buffered = 0; go(0, 0);
    chk("R5 busy while err", busy, 0); chk("R5 byte_done while err", byte_done, 0);
    clr_err = 1; tick(); clr_err = 0;
    buffered = 1;
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    for (int k = 0; k < 33; k++) wr_win(8'h40 + 8'(k));
    set_cnt(1); go(0, 0);
    chk("R3 wrap match xmit", xmit_req, 1);
    peek(0, d); chk("R3 wrapped byte at 0", d, 8'h60);
    peek(1, d); chk("R3 byte at 1", d, 8'h41);
    clr_int();
  endtask

  task automatic t_buf_read();
    go(1, 0);
    chk("R11 fill_req", fill_req, 1);
    for (int k = 0; k < 4; k++) fill(8'hA0 + 8'(k));
    fill_end(4);
    chk("R11 intr", intr, 1); chk("R11 busy held", busy, 1); chk("R11 count", cnt_q, 4);
    clr_int();
    for (int k = 0; k < 4; k++) begin
      chk("R2 window byte", blk_rdata, 8'hA0 + 8'(k));
      if (k < 3) begin rd_win(); chk("R2 busy mid", busy, 1); end
      else rd_win();
    end
    chk("R2 busy drained", busy, 0); chk("R2 op_done", op_done, 1);
    chk("R2 index back to 0", blk_rdata, 8'hA0);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    buffered = 0; wr_win(8'h5A);
    chk("R13 hold on window", blk_rdata, 8'h5A);
    peek(5, d); chk("R13 buffer untouched", d, 8'h45);
  endtask

  task automatic t_byte_write();
    logic [7:0] d;
    wr_win(8'hC0); set_cnt(3); go(0, 0);
    chk("R6 busy", busy, 1); chk("R6 byte_done", byte_done, 1);
    peek(0, d); chk("R6 hold copied to 0", d, 8'hC0);
    wr_win(8'hC1); clr_bd();
    chk("R6 byte_done again", byte_done, 1); peek(1, d); chk("R6 byte 1", d, 8'hC1);
    wr_win(8'hC2); clr_bd();
    peek(2, d); chk("R6 byte 2", d, 8'hC2); chk("R6 no early xmit", xmit_req, 0);
    clr_bd();
    chk("R6 xmit_req", xmit_req, 1); chk("R6 intr", intr, 1); chk("R6 busy clear", busy, 0);
    clr_int();
    clr_bd();
    chk("R7 clear after done: no xmit", xmit_req, 0); chk("R7 byte_done stays 0", byte_done, 0);
  endtask

  task automatic t_byte_read();
    go(1, 0);
    chk("R8 fill_req", fill_req, 1);
    fill(8'hD0); fill(8'hD1); fill(8'hD2); fill_end(3);
    chk("R8 byte_done", byte_done, 1); chk("R8 first byte", blk_rdata, 8'hD0);
    clr_bd();
    chk("R8 second byte", blk_rdata, 8'hD1); chk("R8 byte_done 2", byte_done, 1);
    last_byte = 1; clr_bd(); last_byte = 0;
    chk("R8 final byte", blk_rdata, 8'hD2); chk("R8 intr", intr, 1);
    chk("R8 busy clear", busy, 0); chk("R8 op_done", op_done, 1);
    clr_int();
  endtask

  task automatic t_i2c_read();
    go(1, 1);
    chk("R9 rx_req at start", rx_req, 1); chk("R9 busy", busy, 1);
    clr_bd();
    chk("R7 clear while byte_done low ignored", rx_req, 0);
    chk("R7 hold unchanged", blk_rdata, 8'hD2);
    rx(8'hE0);
    chk("R9 byte_done", byte_done, 1); chk("R9 byte 0", blk_rdata, 8'hE0);
    clr_bd(); chk("R9 rx_req next", rx_req, 1);
    rx(8'hE1); chk("R9 byte 1", blk_rdata, 8'hE1);
    last_byte = 1; clr_bd(); last_byte = 0;
    chk("R9 rx_last_req", rx_last_req, 1); chk("R9 no rx_req", rx_req, 0);
    chk("R9 still busy", busy, 1);
    rx(8'hE2);
    chk("R9 final byte", blk_rdata, 8'hE2); chk("R9 intr", intr, 1);
    chk("R9 busy clear", busy, 0); chk("R9 op_done", op_done, 1);
    clr_int();
  endtask

  task automatic t_abort();
    go(1, 1); rx(8'hF0);
    chk("R10 open read busy", busy, 1);
    go(0, 0);
    chk("R10 stop_req", stop_req, 1); chk("R10 new op busy", busy, 1);
    chk("R10 new op byte_done", byte_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    t_reset(); t_buf_write(); t_buf_mismatch(); t_wrap(); t_buf_read();
    t_hold(); t_byte_write(); t_byte_read(); t_i2c_read(); t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule